// File: doc/BRIEF.md
# Multi-Channel Timer with Carrier Gating

This block is a free-running up-counter shared by several channels. The counter advances on ticks from a power-of-two clock divider and returns to zero after it reaches a programmable terminal count. Each channel either drives a pulse-width output that stays high while the count is below the channel's threshold, or stamps the count when its input pin changes.

In carrier mode the counter ignores the divider and advances once per carrier period, marked by a one-cycle carrier tick input. One chosen channel then has its output ANDed with the carrier waveform. Pulse and gap lengths are therefore counted in carrier cycles and leave the block already modulated.

Software reaches the block through a single-cycle write port and a combinational read port. Terminal count and thresholds are staged and take effect together at the next wrap. Sticky event flags feed one interrupt line through per-source enables.

Top module: `ipt_timer`

## Requirements
- R1: While running (CTRL bit 0 = 1, carrier mode off), the counter advances once every 2^S clocks, where S is CTRL bits 3:1 (0 to 7). After it reaches the active terminal count it returns to 0 on the next tick.
- R2: The count never exceeds the active terminal count. While stopped, the count is held at 0 and staged values are copied straight into the active registers.
- R3: In threshold mode (CHCFG bit 0 = 0), a channel output is high while count < active threshold. A threshold of 0 gives a constant low output. A threshold above the terminal count gives a constant high output.
- R4: While running, writes to the terminal count (address 1) and to a threshold (address 16+n) only update staged copies. The active values, readable at address 4 and 24+n, change only at a wrap.
- R5: In capture mode (CHCFG bit 0 = 1), an edge selected by CHCFG bits 2:1 (01 rising, 10 falling, 11 both) latches the count through a two-stage synchronizer. The latched value is the count during the cycle the pin changed, plus 2, when counting every clock. It is readable at address 16+n, and the capture also sets the channel flag.
- R6: A pin edge that the channel's edge select does not include leaves both the captured value and the flag unchanged.
- R7: STATUS (address 2) holds the wrap flag in bit 0 and the flag of channel n in bit n+1. In threshold mode a channel flag is set when the counter moves onto the active threshold. All flags are sticky and are cleared by writing 1 to their bit; if a set and a clear fall in the same cycle, the set wins.
- R8: irq_o is the OR of the wrap flag ANDed with CTRL bit 8 and each channel flag ANDed with its CHCFG bit 3.
- R9: With CTRL bit 4 = 1, the counter advances only on cycles where carrier_tick_i is high, and the divider setting has no effect.
- R10: With CTRL bit 4 = 1, the channel chosen by CTRL bits 7:5 drives its threshold output ANDed with carrier_i. Other channels are not gated.
- R11: After reset the count is 0, the active terminal count is all ones, CTRL, STATUS and all thresholds are 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address for both write and read |
| wr_data_i | input | CNT_W | Write data |
| rd_data_o | output | CNT_W | Combinational read data for addr_i |
| carrier_i | input | 1 | Carrier waveform used for gating |
| carrier_tick_i | input | 1 | One-cycle pulse per carrier period |
| cap_i | input | NUM_CH | Capture pins, one per channel |
| pwm_o | output | NUM_CH | Channel outputs |
| irq_o | output | 1 | Interrupt request |

## Verification
A register write is visible on the read port in the cycle after its strobe. A tick moves the count at the edge that closes the tick cycle, and the channel output follows one edge later. A capture lands three edges after the pin change: two synchronizer stages, then the latch.

The bench reads the count in the same half-cycle that it changes a pin, and reads the capture back several cycles later. Output widths are measured only after two full counter periods have passed since start. The measuring window is a whole number of periods, so the result does not depend on phase. In carrier mode the bench times its carrier so that each output change lands while the carrier is low, and it samples at the falling clock edge after the carrier has settled.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

   localparam int unsigned ADDR_W    = 5;
   localparam int unsigned PRE_SEL_W = 3;

   // register addresses; channel blocks are 8 apart and indexed by addr[2:0]
   localparam logic [ADDR_W-1:0] A_CTRL     = 5'd0;
   localparam logic [ADDR_W-1:0] A_PERIOD   = 5'd1;
   localparam logic [ADDR_W-1:0] A_STATUS   = 5'd2;
   localparam logic [ADDR_W-1:0] A_COUNT    = 5'd3;
   localparam logic [ADDR_W-1:0] A_PER_ACT  = 5'd4;
   localparam logic [ADDR_W-1:0] A_CFG_BASE = 5'd8;
   localparam logic [ADDR_W-1:0] A_CMP_BASE = 5'd16;
   localparam logic [ADDR_W-1:0] A_ACT_BASE = 5'd24;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   typedef struct packed {
      logic      irq_en;
      edge_sel_e edge_sel;
      logic      capture;
   } chan_cfg_t;

endpackage

// File: rtl/ipt_prescaler.sv
module ipt_prescaler #(
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int unsigned DIV_W = (1 << SEL_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   always_comb mask = DIV_W'((32'd1 << sel_i) - 32'd1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     div_q <= '0;
      else if (!run_i) div_q <= '0;
      else             div_q <= div_q + 1'b1;
   end

   assign tick_o = run_i && ((div_q | ~mask) == '1);

   // R1: divide-by-one ticks on every running cycle
   a_r1_div_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && sel_i == '0) |-> tick_o);

endmodule

// File: rtl/ipt_counter.sv
module ipt_counter #(
   parameter int unsigned       CNT_W        = 16,
   parameter logic [CNT_W-1:0]  PERIOD_RESET = '1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] period_sh_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] period_o,
   output logic             wrap_o,
   output logic             load_o,
   output logic             upd_o
);
   logic [CNT_W-1:0] cnt_q, per_q;
   logic             upd_q;

   assign wrap_o = tick_i && (cnt_q >= per_q);
   assign load_o = wrap_o || !run_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         per_q <= PERIOD_RESET;
         upd_q <= 1'b0;
      end else begin
         upd_q <= tick_i;
         if (!run_i) begin
            cnt_q <= '0;
            per_q <= period_sh_i;
         end else if (wrap_o) begin
            cnt_q <= '0;
            per_q <= period_sh_i;
         end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign count_o  = cnt_q;
   assign period_o = per_q;
   assign upd_o    = upd_q;

   a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= per_q);

   a_r2_stop_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> cnt_q == '0);

   a_r1_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ipt_channel.sv
module ipt_channel #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                capture_i,
   input  ipt_pkg::edge_sel_e  edge_sel_i,
   input  logic [CNT_W-1:0]    cmp_sh_i,
   input  logic                load_i,
   input  logic [CNT_W-1:0]    count_i,
   input  logic                upd_i,
   input  logic                pin_i,
   input  logic                clr_i,
   output logic [CNT_W-1:0]    cmp_act_o,
   output logic [CNT_W-1:0]    cap_o,
   output logic                flag_o,
   output logic                pwm_o
);
   logic [SYNC_STAGES:0] sync_q;
   logic [CNT_W-1:0]     cmp_q, cap_q;
   logic                 flag_q, pwm_q;
   logic                 rise, fall, cap_evt, cmp_evt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-1:0], pin_i};
   end

   assign rise    = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
   assign fall    = ~sync_q[SYNC_STAGES-1] & sync_q[SYNC_STAGES];
   assign cap_evt = capture_i && ((edge_sel_i[0] && rise) || (edge_sel_i[1] && fall));
   assign cmp_evt = !capture_i && upd_i && (count_i == cmp_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmp_q  <= '0;
         cap_q  <= '0;
         flag_q <= 1'b0;
         pwm_q  <= 1'b0;
      end else begin
         if (load_i)  cmp_q <= cmp_sh_i;
         if (cap_evt) cap_q <= count_i;
         if (cap_evt || cmp_evt) flag_q <= 1'b1;
         else if (clr_i)         flag_q <= 1'b0;
         pwm_q <= !capture_i && (count_i < cmp_q);
      end
   end

   assign cmp_act_o = cmp_q;
   assign cap_o     = cap_q;
   assign flag_o    = flag_q;
   assign pwm_o     = pwm_q;

   a_r4_cmp_staged: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(cmp_q));

   a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !clr_i) |=> flag_q);

   a_r6_capture_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rise && !fall) |=> $stable(cap_q));

endmodule

// File: rtl/ipt_timer.sv
module ipt_timer #(
   parameter int unsigned      NUM_CH       = 5,
   parameter int unsigned      CNT_W        = 16,
   parameter int unsigned      SYNC_STAGES  = 2,
   parameter logic [CNT_W-1:0] PERIOD_RESET = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [4:0]        addr_i,
   input  logic [CNT_W-1:0]  wr_data_i,
   output logic [CNT_W-1:0]  rd_data_o,
   input  logic              carrier_i,
   input  logic              carrier_tick_i,
   input  logic [NUM_CH-1:0] cap_i,
   output logic [NUM_CH-1:0] pwm_o,
   output logic              irq_o
);
   import ipt_pkg::*;

   localparam int unsigned CH_IDX_W = 3;

   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_nch
      $error("ipt_timer: NUM_CH must be 1 to 8");
   end
   if (CNT_W < 9 || CNT_W > 32 || CNT_W <= NUM_CH) begin : g_bad_cntw
      $error("ipt_timer: CNT_W must be 9 to 32 and above NUM_CH");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("ipt_timer: SYNC_STAGES must be 1 to 4");
   end

   // control fields
   logic                 run_q, ir_q, ovf_en_q, ovf_q;
   logic [PRE_SEL_W-1:0] pre_q;
   logic [CH_IDX_W-1:0]  irch_q;
   logic [CNT_W-1:0]     per_sh_q;
   chan_cfg_t            cfg_q    [NUM_CH];
   logic [CNT_W-1:0]     cmp_sh_q [NUM_CH];

   logic [CNT_W-1:0] count, per_act;
   logic [CNT_W-1:0] cmp_act [NUM_CH];
   logic [CNT_W-1:0] cap_val [NUM_CH];
   logic [NUM_CH-1:0] ch_flag, ch_pwm, ch_clr, ch_irq_en;
   logic pre_tick, tick, wrap, load, upd;
   logic wr_status;

   assign wr_status = wr_en_i && (addr_i == A_STATUS);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q    <= 1'b0;
         pre_q    <= '0;
         ir_q     <= 1'b0;
         irch_q   <= '0;
         ovf_en_q <= 1'b0;
         ovf_q    <= 1'b0;
         per_sh_q <= PERIOD_RESET;
         for (int n = 0; n < NUM_CH; n++) begin
            cfg_q[n]    <= '0;
            cmp_sh_q[n] <= '0;
         end
      end else begin
         if (wr_en_i && addr_i == A_CTRL) begin
            run_q    <= wr_data_i[0];
            pre_q    <= wr_data_i[3:1];
            ir_q     <= wr_data_i[4];
            irch_q   <= wr_data_i[7:5];
            ovf_en_q <= wr_data_i[8];
         end
         if (wr_en_i && addr_i == A_PERIOD) per_sh_q <= wr_data_i;
         for (int n = 0; n < NUM_CH; n++) begin
            if (wr_en_i && addr_i == (A_CFG_BASE | 5'(n))) cfg_q[n]    <= chan_cfg_t'(wr_data_i[3:0]);
            if (wr_en_i && addr_i == (A_CMP_BASE | 5'(n))) cmp_sh_q[n] <= wr_data_i;
         end
         if (wrap)                          ovf_q <= 1'b1;
         else if (wr_status && wr_data_i[0]) ovf_q <= 1'b0;
      end
   end

   ipt_prescaler #(.SEL_W(PRE_SEL_W)) i_prescaler (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_q && !ir_q),
      .sel_i  (pre_q),
      .tick_o (pre_tick)
   );

   assign tick = run_q && (ir_q ? carrier_tick_i : pre_tick);

   ipt_counter #(.CNT_W(CNT_W), .PERIOD_RESET(PERIOD_RESET)) i_counter (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run_q),
      .tick_i      (tick),
      .period_sh_i (per_sh_q),
      .count_o     (count),
      .period_o    (per_act),
      .wrap_o      (wrap),
      .load_o      (load),
      .upd_o       (upd)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      assign ch_clr[n]    = wr_status && wr_data_i[n+1];
      assign ch_irq_en[n] = cfg_q[n].irq_en;

      ipt_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_channel (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .capture_i  (cfg_q[n].capture),
         .edge_sel_i (cfg_q[n].edge_sel),
         .cmp_sh_i   (cmp_sh_q[n]),
         .load_i     (load),
         .count_i    (count),
         .upd_i      (upd),
         .pin_i      (cap_i[n]),
         .clr_i      (ch_clr[n]),
         .cmp_act_o  (cmp_act[n]),
         .cap_o      (cap_val[n]),
         .flag_o     (ch_flag[n]),
         .pwm_o      (ch_pwm[n])
      );

      assign pwm_o[n] = ch_pwm[n] & ((ir_q && irch_q == CH_IDX_W'(n)) ? carrier_i : 1'b1);

      // R10: the gated channel stays low whenever the carrier is low
      a_r10_carrier_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ir_q && irch_q == CH_IDX_W'(n) && !carrier_i) |-> !pwm_o[n]);
   end

   assign irq_o = (ovf_q && ovf_en_q) || |(ch_flag & ch_irq_en);

   always_comb begin
      rd_data_o = '0;
      case (addr_i[4:3])
         2'b00: begin
            case (addr_i[2:0])
               3'd0: begin
                  rd_data_o[0]   = run_q;
                  rd_data_o[3:1] = pre_q;
                  rd_data_o[4]   = ir_q;
                  rd_data_o[7:5] = irch_q;
                  rd_data_o[8]   = ovf_en_q;
               end
               3'd1: rd_data_o = per_sh_q;
               3'd2: begin
                  rd_data_o[0]        = ovf_q;
                  rd_data_o[NUM_CH:1] = ch_flag;
               end
               3'd3: rd_data_o = count;
               3'd4: rd_data_o = per_act;
               default: rd_data_o = '0;
            endcase
         end
         2'b01: begin
            for (int n = 0; n < NUM_CH; n++)
               if (addr_i[2:0] == 3'(n)) rd_data_o = CNT_W'(cfg_q[n]);
         end
         2'b10: begin
            for (int n = 0; n < NUM_CH; n++)
               if (addr_i[2:0] == 3'(n)) rd_data_o = cfg_q[n].capture ? cap_val[n] : cmp_sh_q[n];
         end
         default: begin
            for (int n = 0; n < NUM_CH; n++)
               if (addr_i[2:0] == 3'(n)) rd_data_o = cmp_act[n];
         end
      endcase
   end

   // R7: the wrap flag holds until a clearing write
   a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_q && !(wr_status && wr_data_i[0])) |=> ovf_q);

   // R4: the active terminal count moves only at a wrap or while stopped
   a_r4_period_staged: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && !wrap) |=> $stable(per_act));

endmodule

// File: tb/test_ipt_timer.sv
module test_ipt_timer;
   import ipt_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 5;
   localparam int W          = 16;

   typedef struct packed {
      logic [2:0]  sel;
      logic [15:0] per;
      logic [15:0] cmp;
      logic [15:0] hi;   // expected high clocks per counter period
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{3'd0, 16'd9, 16'd3, 16'd3},
      '{3'd1, 16'd4, 16'd2, 16'd4},
      '{3'd2, 16'd7, 16'd0, 16'd0},
      '{3'd0, 16'd5, 16'd9, 16'd6},
      '{3'd3, 16'd3, 16'd1, 16'd8},
      '{3'd0, 16'd0, 16'd1, 16'd1},
      '{3'd7, 16'd1, 16'd1, 16'd128},
      '{3'd2, 16'd6, 16'd6, 16'd24}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [4:0]     addr = '0;
   logic [W-1:0]   wdata = '0;
   logic [W-1:0]   rdata;
   logic           carrier = 1'b0;
   logic           ctick = 1'b0;
   logic [NCH-1:0] cap = '0;
   logic [NCH-1:0] pwm;
   logic           irq;

   int errors = 0;
   int checks = 0;
   bit car_on = 1'b0;
   int phase  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipt_timer #(.NUM_CH(NCH), .CNT_W(W), .SYNC_STAGES(2), .PERIOD_RESET(16'hFFFF)) i_ipt_timer (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .wr_en_i        (wr_en),
      .addr_i         (addr),
      .wr_data_i      (wdata),
      .rd_data_o      (rdata),
      .carrier_i      (carrier),
      .carrier_tick_i (ctick),
      .cap_i          (cap),
      .pwm_o          (pwm),
      .irq_o          (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [W-1:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic count_high(input int ch, input int n, output int hi);
      hi = 0;
      repeat (n) begin
         @(negedge clk);
         #2 if (pwm[ch]) hi++;
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // carrier source: four clocks per period, high in the last two, tick in the first
   initial begin
      forever begin
         @(negedge clk);
         if (car_on) phase = (phase + 1) % 4;
         else        phase = 3;
         carrier = car_on && (phase >= 2);
         ctick   = car_on && (phase == 0);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      logic [W-1:0] d, c0;
      int h0, h1, bad;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      rd(A_COUNT, d);   check("R11 count", d, 0);
      rd(A_PER_ACT, d); check("R11 period", d, 16'hFFFF);
      rd(A_CTRL, d);    check("R11 ctrl", d, 0);
      rd(A_STATUS, d);  check("R11 status", d, 0);
      check("R11 outputs", {pwm, irq}, 0);

      // R1/R3 table: divider, terminal count, threshold -> high clocks per period
      for (int v = 0; v < 8; v++) begin
         int div, span, hi;
         div  = 1 << VEC[v].sel;
         span = (int'(VEC[v].per) + 1) * div;
         wr(A_CTRL, 16'h0);
         wr(A_PERIOD, VEC[v].per);
         wr(A_CMP_BASE, VEC[v].cmp);
         wr(A_CTRL, 16'({VEC[v].sel, 1'b1}));
         repeat (2 * span + 4) @(negedge clk);
         count_high(0, 2 * span, hi);
         check($sformatf("R1/R3 vector %0d", v), hi, 2 * int'(VEC[v].hi));
      end

      // R4 staged terminal count and threshold
      wr(A_CTRL, 16'h0);
      wr(A_PERIOD, 16'd99);
      wr(A_CMP_BASE, 16'd50);
      wr(A_CTRL, 16'h1);
      repeat (10) @(negedge clk);
      wr(A_CMP_BASE, 16'd20);
      wr(A_PERIOD, 16'd49);
      rd(A_ACT_BASE, d);  check("R4 threshold held", d, 50);
      rd(A_PER_ACT, d);   check("R4 period held", d, 99);
      repeat (100) @(negedge clk);
      rd(A_ACT_BASE, d);  check("R4 threshold at wrap", d, 20);
      rd(A_PER_ACT, d);   check("R4 period at wrap", d, 49);

      // R2 stop clears the count
      wr(A_CTRL, 16'h0);
      rd(A_COUNT, d);     check("R2 stopped count", d, 0);

      // R7 / R8 wrap flag and interrupt enable
      wr(A_STATUS, 16'hFFFF);
      wr(A_PERIOD, 16'd3);
      wr(A_CTRL, 16'h1);
      repeat (10) @(negedge clk);
      rd(A_STATUS, d);    check("R7 wrap flag", d[0], 1);
      check("R8 irq masked", irq, 0);
      wr(A_CTRL, 16'h101);
      #1 check("R8 irq enabled", irq, 1);
      wr(A_CTRL, 16'h100);
      #1 check("R7 flag sticky", irq, 1);
      wr(A_STATUS, 16'h1);
      rd(A_STATUS, d);    check("R7 write-one clear", d[0], 0);
      check("R8 irq cleared", irq, 0);
      wr(A_CTRL, 16'h0);

      // R5 capture on rising edge, channel 2 (status bit 3)
      wr(A_CFG_BASE | 5'd2, 16'h3);
      wr(A_PERIOD, 16'hFFFF);
      wr(A_CTRL, 16'h1);
      repeat (20) @(negedge clk);
      @(negedge clk); addr = A_COUNT; #1 c0 = rdata; cap[2] = 1'b1;
      repeat (6) @(negedge clk);
      rd(A_CMP_BASE | 5'd2, d); check("R5 rising value", d, c0 + 16'd2);
      rd(A_STATUS, d);          check("R5 rising flag", d[3], 1);

      // R5 falling edge
      wr(A_CFG_BASE | 5'd2, 16'h5);
      wr(A_STATUS, 16'h8);
      @(negedge clk); addr = A_COUNT; #1 c0 = rdata; cap[2] = 1'b0;
      repeat (6) @(negedge clk);
      rd(A_CMP_BASE | 5'd2, d); check("R5 falling value", d, c0 + 16'd2);
      rd(A_STATUS, d);          check("R5 falling flag", d[3], 1);

      // R6 rising edge ignored under falling-only select
      wr(A_STATUS, 16'h8);
      @(negedge clk); cap[2] = 1'b1;
      repeat (6) @(negedge clk);
      rd(A_CMP_BASE | 5'd2, d); check("R6 value kept", d, c0 + 16'd2);
      rd(A_STATUS, d);          check("R6 flag kept clear", d[3], 0);

      // R5 both edges, with channel interrupt enabled (R8)
      wr(A_CFG_BASE | 5'd2, 16'hF);
      @(negedge clk); addr = A_COUNT; #1 c0 = rdata; cap[2] = 1'b0;
      repeat (6) @(negedge clk);
      rd(A_CMP_BASE | 5'd2, d); check("R5 both value", d, c0 + 16'd2);
      check("R8 channel irq", irq, 1);
      wr(A_CFG_BASE | 5'd2, 16'h0);
      wr(A_STATUS, 16'hFFFF);
      #1 check("R8 channel irq cleared", irq, 0);

      // R9 / R10 carrier mode, divider field set to 7 to show it is ignored
      wr(A_CTRL, 16'h0);
      wr(A_PERIOD, 16'd3);
      wr(A_CMP_BASE, 16'd2);
      wr(A_CMP_BASE | 5'd1, 16'd2);
      wr(A_CTRL, 16'h1F);
      repeat (20) @(negedge clk);
      rd(A_COUNT, d);     check("R9 no carrier tick holds count", d, 0);
      car_on = 1'b1;
      repeat (40) @(negedge clk);
      h0 = 0; h1 = 0; bad = 0;
      for (int k = 0; k < 32; k++) begin
         @(negedge clk);
         #2;
         if (pwm[0]) h0++;
         if (pwm[1]) h1++;
         if (pwm[0] && !carrier) bad++;
      end
      check("R10 gated channel highs", h0, 8);
      check("R10 gate follows carrier", bad, 0);
      check("R9 ungated channel counts carrier periods", h1, 16);
      car_on = 1'b0;
      wr(A_CTRL, 16'h0);

      summary();
      $finish;
   end

endmodule